// File: doc/BRIEF.md
# Asynchronous SRAM port controller

This block lets a clocked host perform single-word reads and writes on an external asynchronous static RAM of 128K words by 16 bits with two byte lanes. The host raises a one-cycle request with a write flag, a word address, write data and a two-bit lane mask. The controller then drives the memory's two chip selects (one active-low, one active-high), its write strobe, output enable, per-lane byte strobes, address and a split tri-state data bus. When the access completes it pulses a done flag, and for reads it also pulses a read-valid flag.

Every phase length is a whole number of clock cycles. Each count is computed at elaboration from the clock period and a speed-grade parameter. The count is the minimum memory time divided by the period, rounded up, and never less than one. Between accesses the memory is left deselected with the bus released, so the part sits in its automatic standby. A write that follows a read first waits out the time the memory may keep driving the bus after its output is disabled.

Top module: `asram_port`

## Requirements
- R1: During reset and whenever no access is in progress: memCeN=1, memCe2=0, memWeN=1, memOeN=1, memLbN=1, memUbN=1, memDqOe=0, hostDone=0 and hostRdValid=0.
- R2: A read accepted at a clock edge holds memCeN=0, memCe2=1, memOeN=0 and memWeN=1 for ceil(max(tAA,tOE,tBA)/period) cycles, which is 7 at the default parameters (fast grade: 55, 25, 25 ns; 8 ns period). hostDone and hostRdValid are then high together for exactly one cycle, so done is observed 8 cycles after acceptance.
- R3: hostRdata holds the memory bus value sampled on the last access cycle. A lane whose mask bit is 0 returns zero. Mask bit 0 covers data bits 7:0 and bit 1 covers bits 15:8.
- R4: While the memory is selected, memLbN = !mask[0] and memUbN = !mask[1]. A write leaves a lane with a low mask bit unchanged in memory.
- R5: A write holds memWeN=0 with both chip selects active for ceil(max(tWP,tAW,tBW,tDW)/period) cycles, which is 6 at the defaults (fast grade: 40, 45, 45, 25 ns). It never overlaps memOeN=0. hostDone then pulses for one cycle with hostRdValid low, 7 cycles after acceptance when no turnaround applies.
- R6: memDqOe is high only while memWeN is low, and memDqOut then carries the request's write data.
- R7: A write accepted after a read waits ceil(tOHZ/period) turnaround cycles (3 at the defaults, tOHZ fast = 20 ns) with the memory deselected before memWeN falls. The controller's drivers never overlap the memory still driving. A write after a write, or the first access after reset, does not wait.
- R8: A request is taken only when the controller is idle. A request raised during an access has no effect on the memory and produces no extra done pulse.
- R9: memAddr equals the request address and stays constant for every cycle the memory is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | One-cycle access request, taken only when idle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 17 | Word address |
| hostWdata | input | 16 | Write data |
| hostBe | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| hostDone | output | 1 | One-cycle completion pulse |
| hostRdValid | output | 1 | One-cycle pulse when hostRdata is valid |
| hostRdata | output | 16 | Read data, masked lanes zero |
| memCeN | output | 1 | Active-low chip select |
| memCe2 | output | 1 | Active-high chip select |
| memWeN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low output enable |
| memLbN | output | 1 | Active-low lower lane strobe |
| memUbN | output | 1 | Active-low upper lane strobe |
| memAddr | output | 17 | Memory address |
| memDqIn | input | 16 | Data bus value seen at the pins |
| memDqOut | output | 16 | Data the controller drives |
| memDqOe | output | 1 | Drive enable for memDqOut |

## Verification
The bench builds the block with an 8000 ps clock period and the fast grade. This gives 7 read cycles, 6 write-strobe cycles and 3 turnaround cycles, so every phase counter runs across several values and its terminal count is observable. The bench's memory model keeps driving for two cycles after its output is disabled. A missing or shortened turnaround therefore shows up as bus contention, and unselected lanes float to a non-zero pattern, so lane masking can be seen at the ports.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TURN  = 2'd1,
    ST_WRITE = 2'd2,
    ST_READ  = 2'd3
  } seqState_t;

  // Strobes from sequencer to datapath
  typedef struct packed {
    logic load;      // latch request fields
    logic select;    // memory selected
    logic readEn;    // output enable phase
    logic writeEn;   // write strobe phase
    logic capture;   // last read cycle: sample bus
    logic finishWr;  // last write cycle
  } seqStrobe_t;

  // Minimum time in ps to whole cycles, never below one
  function automatic int cyclesFor(input int timePs, input int periodPs);
    int c;
    c = (timePs + periodPs - 1) / periodPs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC = 7,
  parameter int WR_CYC = 6,
  parameter int TA_CYC = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostReq,
  input  logic       hostWrite,
  output seqStrobe_t strobe
);

  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, WR_CYC), TA_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             lastRead;
  logic             cntZero;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lastRead <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (hostReq) begin
            if (hostWrite) begin
              lastRead <= 1'b0;
              if (lastRead) begin
                state <= ST_TURN;
                cnt   <= CNT_W'(TA_CYC - 1);
              end else begin
                state <= ST_WRITE;
                cnt   <= CNT_W'(WR_CYC - 1);
              end
            end else begin
              state <= ST_READ;
              cnt   <= CNT_W'(RD_CYC - 1);
            end
          end
        end
        ST_TURN: begin
          if (cntZero) begin
            state <= ST_WRITE;
            cnt   <= CNT_W'(WR_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WRITE: begin
          if (cntZero) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        ST_READ: begin
          if (cntZero) begin
            state    <= ST_IDLE;
            lastRead <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.load     = (state == ST_IDLE) && hostReq;
    strobe.select   = (state == ST_WRITE) || (state == ST_READ);
    strobe.readEn   = (state == ST_READ);
    strobe.writeEn  = (state == ST_WRITE);
    strobe.capture  = (state == ST_READ) && cntZero;
    strobe.finishWr = (state == ST_WRITE) && cntZero;
  end

  // Turnaround is entered only straight from idle after a read
  AST_TURN_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_TURN) |-> $past(state) == ST_IDLE && $past(lastRead)); // R7

  // Phase counter never exceeds the longest phase
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cnt < CNT_W'(MAX_CYC)); // R2

endmodule

// File: rtl/asram_dp.sv
module asram_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W/8-1:0] hostBe,
  output logic              hostDone,
  output logic              hostRdValid,
  output logic [DATA_W-1:0] hostRdata,
  output logic              memCeN,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W/8-1:0] laneN,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  beQ;
  logic [DATA_W-1:0] rdataQ;
  logic [DATA_W-1:0] laneMask;
  logic              doneQ;
  logic              rdValidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
    end else if (strobe.load) begin
      addrQ  <= hostAddr;
      wdataQ <= hostWdata;
      beQ    <= hostBe;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneMask[l*8 +: 8] = {8{beQ[l]}};
    assign laneN[l]           = !(strobe.select && beQ[l]);

    always_ff @(posedge clk) begin
      if (!rstN)               rdataQ[l*8 +: 8] <= '0;
      else if (strobe.capture) rdataQ[l*8 +: 8] <= beQ[l] ? memDqIn[l*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ    <= 1'b0;
      rdValidQ <= 1'b0;
    end else begin
      doneQ    <= strobe.capture || strobe.finishWr;
      rdValidQ <= strobe.capture;
    end
  end

  assign hostDone    = doneQ;
  assign hostRdValid = rdValidQ;
  assign hostRdata   = rdataQ;
  assign memCeN      = !strobe.select;
  assign memCe2      = strobe.select;
  assign memWeN      = !strobe.writeEn;
  assign memOeN      = !strobe.readEn;
  assign memAddr     = addrQ;
  assign memDqOut    = wdataQ;
  assign memDqOe     = strobe.writeEn;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone); // R2

  AST_RDV_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    hostRdValid |-> hostDone); // R2

  AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    hostRdValid |-> (hostRdata & ~laneMask) == '0); // R3

endmodule

// File: rtl/asram_port.sv
module asram_port
  import asram_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 8000,
  parameter bit FAST_GRADE    = 1'b1,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [1:0]        hostBe,
  output logic              hostDone,
  output logic              hostRdValid,
  output logic [DATA_W-1:0] hostRdata,
  output logic              memCeN,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe
);

  // Grade minimums in ps
  localparam int T_WP  = FAST_GRADE ? 40000 : 50000;
  localparam int T_AW  = FAST_GRADE ? 45000 : 60000;
  localparam int T_BW  = FAST_GRADE ? 45000 : 60000;
  localparam int T_DW  = FAST_GRADE ? 25000 : 30000;
  localparam int T_AA  = FAST_GRADE ? 55000 : 70000;
  localparam int T_OE  = FAST_GRADE ? 25000 : 35000;
  localparam int T_BA  = FAST_GRADE ? 25000 : 35000;
  localparam int T_OHZ = FAST_GRADE ? 20000 : 25000;

  localparam int RD_CYC = cyclesFor(maxOf(T_AA, maxOf(T_OE, T_BA)), CLK_PERIOD_PS);
  localparam int WR_CYC = cyclesFor(maxOf(maxOf(T_WP, T_AW), maxOf(T_BW, T_DW)), CLK_PERIOD_PS);
  localparam int TA_CYC = cyclesFor(T_OHZ, CLK_PERIOD_PS);
  localparam int CHK_W  = $clog2(maxOf(RD_CYC, maxOf(WR_CYC, TA_CYC)) + 2);

  seqStrobe_t strobe;
  logic [1:0] laneN;

  asram_seq #(
    .RD_CYC(RD_CYC),
    .WR_CYC(WR_CYC),
    .TA_CYC(TA_CYC)
  ) u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .hostReq  (hostReq),
    .hostWrite(hostWrite),
    .strobe   (strobe)
  );

  asram_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hostAddr   (hostAddr),
    .hostWdata  (hostWdata),
    .hostBe     (hostBe),
    .hostDone   (hostDone),
    .hostRdValid(hostRdValid),
    .hostRdata  (hostRdata),
    .memCeN     (memCeN),
    .memCe2     (memCe2),
    .memWeN     (memWeN),
    .memOeN     (memOeN),
    .laneN      (laneN),
    .memAddr    (memAddr),
    .memDqIn    (memDqIn),
    .memDqOut   (memDqOut),
    .memDqOe    (memDqOe)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[1];

  // Pin-level run counters for the timing checks
  logic [CHK_W-1:0] weRun;
  logic [CHK_W-1:0] oeRun;
  logic [CHK_W-1:0] sinceRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weRun     <= '0;
      oeRun     <= '0;
      sinceRead <= CHK_W'(TA_CYC);
    end else begin
      weRun <= memWeN ? '0 : weRun + 1'b1;
      oeRun <= memOeN ? '0 : oeRun + 1'b1;
      if (!memOeN)                          sinceRead <= '0;
      else if (sinceRead != CHK_W'(TA_CYC)) sinceRead <= sinceRead + 1'b1;
    end
  end

  AST_STANDBY_PINS: assert property (@(posedge clk) disable iff (!rstN)
    memCeN |-> !memCe2 && memWeN && memOeN && memLbN && memUbN && !memDqOe); // R1

  AST_READ_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> oeRun == CHK_W'(RD_CYC)); // R2

  AST_WRITE_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> weRun == CHK_W'(WR_CYC)); // R5

  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN)); // R5

  AST_DRIVE_IN_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> !memWeN && !memCeN && memCe2); // R6

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> sinceRead >= CHK_W'(TA_CYC)); // R7

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr)); // R9

endmodule

// File: tb/sim_asram_port.sv
module sim_asram_port;

  // Expected phase counts at 8 ns, fast grade (see R2, R5, R7)
  localparam int EXP_RD = 7;
  localparam int EXP_WR = 6;
  localparam int EXP_TA = 3;
  localparam int HOLD_CYC = 3;   // model keeps driving after output disable

  typedef struct packed {
    logic        wr;
    logic [16:0] addr;
    logic [15:0] data;
    logic [1:0]  be;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 17'h00010, 16'h1234, 2'b11, 16'h0000},
    '{1'b1, 17'h1FFFF, 16'hABCD, 2'b11, 16'h0000},
    '{1'b0, 17'h00010, 16'h0000, 2'b11, 16'h1234},
    '{1'b0, 17'h1FFFF, 16'h0000, 2'b11, 16'hABCD},
    '{1'b1, 17'h00010, 16'h5678, 2'b01, 16'h0000},
    '{1'b0, 17'h00010, 16'h0000, 2'b11, 16'h1278},
    '{1'b1, 17'h00010, 16'hEEFF, 2'b10, 16'h0000},
    '{1'b0, 17'h00010, 16'h0000, 2'b01, 16'h0078},
    '{1'b0, 17'h00010, 16'h0000, 2'b10, 16'hEE00},
    '{1'b0, 17'h1FFFF, 16'h0000, 2'b00, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0;
  logic        hostWrite = 1'b0;
  logic [16:0] hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [1:0]  hostBe = '0;
  logic        hostDone, hostRdValid;
  logic [15:0] hostRdata;
  logic        memCeN, memCe2, memWeN, memOeN, memLbN, memUbN;
  logic [16:0] memAddr;
  logic [15:0] memDqIn, memDqOut;
  logic        memDqOe;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;   // 125 MHz

  asram_port #(
    .CLK_PERIOD_PS(8000),
    .FAST_GRADE   (1'b1)
  ) u0 (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostBe(hostBe),
    .hostDone(hostDone), .hostRdValid(hostRdValid), .hostRdata(hostRdata),
    .memCeN(memCeN), .memCe2(memCe2), .memWeN(memWeN), .memOeN(memOeN),
    .memLbN(memLbN), .memUbN(memUbN), .memAddr(memAddr),
    .memDqIn(memDqIn), .memDqOut(memDqOut), .memDqOe(memDqOe)
  );

  // Memory model
  logic [15:0] memArr [int];
  logic [1:0]  laneDrv = 2'b00;
  logic [15:0] modelQ = '0;
  int          hold = 0;
  bit          contention = 0;
  bit          driveBad = 0;

  function automatic logic [15:0] rdMem(input int a);
    return memArr.exists(a) ? memArr[a] : 16'h0000;
  endfunction

  assign memDqIn[7:0]  = laneDrv[0] ? modelQ[7:0]  : (memDqOe ? memDqOut[7:0]  : 8'hA5);
  assign memDqIn[15:8] = laneDrv[1] ? modelQ[15:8] : (memDqOe ? memDqOut[15:8] : 8'hA5);

  always @(negedge clk) begin
    logic        sel;
    logic [15:0] w;
    sel = !memCeN && memCe2;
    if (memDqOe && laneDrv != 2'b00) contention = 1;
    if (memDqOe && memWeN) driveBad = 1;
    if (sel && !memWeN) begin
      if (!memDqOe) driveBad = 1;
      w = rdMem(int'(memAddr));
      if (!memLbN) w[7:0]  = memDqOut[7:0];
      if (!memUbN) w[15:8] = memDqOut[15:8];
      memArr[int'(memAddr)] = w;
    end
    if (sel && !memOeN && memWeN) begin
      laneDrv = {!memUbN, !memLbN};
      modelQ  = rdMem(int'(memAddr));
      hold    = HOLD_CYC;
    end else if (hold > 0) begin
      hold = hold - 1;
      if (hold == 0) laneDrv = 2'b00;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chkIdle(input string what);
    chk({memCeN, memCe2, memWeN, memOeN, memLbN, memUbN, memDqOe, hostDone, hostRdValid}
        == 9'b101111000, "R1", what,
        {23'd0, memCeN, memCe2, memWeN, memOeN, memLbN, memUbN, memDqOe, hostDone, hostRdValid},
        32'h178);
  endtask

  // Called at a negedge; returns at the negedge where done is seen
  task automatic doOp(input logic wr, input logic [16:0] a, input logic [15:0] d,
                      input logic [1:0] be, output int lat, output int weCnt,
                      output int oeCnt, output logic [15:0] rd, output logic rdv,
                      output bit addrOk, output bit laneOk);
    hostReq = 1'b1; hostWrite = wr; hostAddr = a; hostWdata = d; hostBe = be;
    @(negedge clk);
    hostReq = 1'b0;
    lat = 1; weCnt = 0; oeCnt = 0; addrOk = 1; laneOk = 1;
    while (!hostDone && lat < 64) begin
      if (!memWeN) weCnt++;
      if (!memOeN) oeCnt++;
      if (!memCeN) begin
        if (memAddr != a || !memCe2) addrOk = 0;
        if ({memUbN, memLbN} != ~be) laneOk = 0;
      end
      @(negedge clk);
      lat++;
    end
    rd = hostRdata;
    rdv = hostRdValid;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat, weCnt, oeCnt, expLat, dones;
    logic [15:0] rd;
    logic rdv;
    bit addrOk, laneOk, prevRead;

    // R1: reset state
    repeat (3) @(negedge clk);
    chkIdle("pins in reset");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chkIdle("pins idle after reset");

    // Table-driven accesses
    prevRead = 0;
    foreach (VECS[i]) begin
      doOp(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].be, lat, weCnt, oeCnt, rd, rdv, addrOk, laneOk);
      if (VECS[i].wr) begin
        expLat = prevRead ? 1 + EXP_TA + EXP_WR : 1 + EXP_WR;
        chk(lat == expLat, "R7", "write latency", lat, expLat);
        chk(weCnt == EXP_WR, "R5", "write strobe cycles", weCnt, EXP_WR);
        chk(oeCnt == 0, "R5", "no output enable in write", oeCnt, 0);
        chk(rdv == 1'b0, "R5", "no read valid on write", rdv, 0);
      end else begin
        chk(lat == 1 + EXP_RD, "R2", "read latency", lat, 1 + EXP_RD);
        chk(oeCnt == EXP_RD, "R2", "output enable cycles", oeCnt, EXP_RD);
        chk(rdv == 1'b1, "R2", "read valid with done", rdv, 1);
        chk(rd == VECS[i].exp, "R3", "read data", rd, VECS[i].exp);
      end
      chk(addrOk, "R9", "address held", memAddr, VECS[i].addr);
      chk(laneOk, "R4", "lane strobes", {memUbN, memLbN}, ~VECS[i].be);
      prevRead = !VECS[i].wr;
    end

    // R8: request during a busy read is dropped
    @(negedge clk);
    hostReq = 1'b1; hostWrite = 1'b0; hostAddr = 17'h00010; hostBe = 2'b11;
    @(negedge clk);
    hostReq = 1'b1; hostWrite = 1'b1; hostAddr = 17'h00020; hostWdata = 16'hFFFF;
    @(negedge clk);
    hostReq = 1'b0;
    dones = 0;
    while (!hostDone && dones < 64) begin @(negedge clk); dones++; end
    chk(hostDone && hostRdata == 16'hEE78, "R3", "read before busy request", hostRdata, 16'hEE78);
    @(negedge clk);
    chk(!hostDone, "R2", "done lasts one cycle", hostDone, 0);
    dones = 0;
    repeat (30) begin
      if (hostDone) dones++;
      @(negedge clk);
    end
    chk(dones == 0, "R8", "no extra done", dones, 0);
    chkIdle("idle after dropped request");
    doOp(1'b0, 17'h00020, 16'h0000, 2'b11, lat, weCnt, oeCnt, rd, rdv, addrOk, laneOk);
    chk(rd == 16'h0000, "R8", "dropped write left memory", rd, 0);

    // R7: write right after this read, bus handover clean
    doOp(1'b1, 17'h00030, 16'h0F0F, 2'b11, lat, weCnt, oeCnt, rd, rdv, addrOk, laneOk);
    chk(lat == 1 + EXP_TA + EXP_WR, "R7", "turnaround latency", lat, 1 + EXP_TA + EXP_WR);
    doOp(1'b0, 17'h00030, 16'h0000, 2'b11, lat, weCnt, oeCnt, rd, rdv, addrOk, laneOk);
    chk(rd == 16'h0F0F, "R6", "written data reached memory", rd, 16'h0F0F);

    @(negedge clk);
    chk(!contention, "R7", "no bus contention", contention, 0);
    chk(!driveBad, "R6", "drive only under write strobe", driveBad, 0);
    chkIdle("idle at end");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule